// File: doc/BRIEF.md
# Prioritised Interrupt Request and Vector Unit

This block sits beside a small 8-bit CPU core and decides, at each instruction boundary, whether the core should leave its instruction stream for an interrupt and which vector it should fetch. It tracks two hardware sources and one software source. The hardware sources are an active-low external request pin and a timer request level. The software source is the software-interrupt opcode, which the core reports as already fetched. The core's interrupt mask bit gates the hardware sources. A hardware request that comes in while the mask is set is kept, not lost.

The core pulses an end-of-instruction strobe. If the unit accepts a source, it raises `take_o` on the next cycle and holds it, together with a stable vector address, until the core pulses the acknowledge strobe once stacking is done. A build-time parameter selects how the external pin is sensed. It can be falling-edge only, or edge plus low level. With level sensing, a pin that is still low after service raises a new request. A flag from the core marks the low-power wait state. A timer request taken while that flag is latched uses a separate vector.

Top module: `irqv_unit`

## Requirements
- R1: While reset is asserted and after it is released, `take_o` is 0 and `vec_o` is 13'h1FFE. The external request latch and the wait latch are clear.
- R2: A decision is made only in a cycle where `eoi_i` is 1. A pending request never raises `take_o` without that strobe.
- R3: With `imask_i` at 0 and both hardware sources pending, the external request wins with vector 13'h1FFA. The timer alone gives 13'h1FF8.
- R4: While `imask_i` is 1, no hardware source is taken. An external falling edge seen in that time stays latched and is taken at the first boundary after `imask_i` returns to 0.
- R5: With `swi_i` at 1, the software vector 13'h1FFC is taken whenever `imask_i` is 1. It is also taken when `imask_i` is 0 and no hardware source is pending. When `imask_i` is 0 and a hardware source is pending, the hardware source is taken instead.
- R6: In edge-only mode (`LEVEL_SENS`=0), an acknowledge of an external take clears the request. A pin held low afterwards raises no new request.
- R7: In level mode (`LEVEL_SENS`=1), a pin still low after the acknowledge of an external take raises a new external request.
- R8: The external request latch is cleared only by the acknowledge of an external take. A timer or software take leaves it unchanged.
- R9: A timer take while the wait latch is set gives vector 13'h1FF6. The wait latch is set by `wait_i` and cleared by the first acknowledge. So when both sources are pending in wait, the external one goes first and the timer then uses 13'h1FF8.
- R10: `take_o` stays 1 and `vec_o` stays constant from the cycle after the accepting strobe until an `ack_i` pulse. Strobes in that window are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_ni | input | 1 | External request pin, active low, asynchronous |
| tmr_req_i | input | 1 | Timer request level (held by the timer until cleared by software) |
| imask_i | input | 1 | CPU interrupt mask bit |
| eoi_i | input | 1 | End-of-instruction strobe |
| swi_i | input | 1 | Next fetched opcode is a software interrupt |
| wait_i | input | 1 | CPU is in the low-power wait state |
| ack_i | input | 1 | Stacking done, current take acknowledged |
| take_o | output | 1 | Interrupt taken, held until acknowledge |
| vec_o | output | ADDR_W | Vector address of the taken source |

## Verification
The bench drives both sensing variants from the same stimulus, so that a pin still low after acknowledge must give a new take in level mode and none in edge mode. If the acknowledge did not clear the latch, edge mode would fire twice. If the level path were missing, level mode would go silent. A pulse on the pin while masked checks that the latch survives until the mask drops; a design that sampled only the live pin would miss it. Wake from wait with both sources pending checks that the external one goes first. The timer must then use the normal vector; a wait flag that was not cleared on acknowledge would return the wait vector twice. Strobes issued while a take is outstanding check that the vector stays fixed.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_IRQ  = 2'd1,
    SRC_TMR  = 2'd2,
    SRC_SWI  = 2'd3
  } irq_src_e;

  // vector offsets below the top of the address space
  localparam int unsigned VOFF_RST      = 1;
  localparam int unsigned VOFF_SWI      = 3;
  localparam int unsigned VOFF_IRQ      = 5;
  localparam int unsigned VOFF_TMR      = 7;
  localparam int unsigned VOFF_TMR_WAIT = 9;

endpackage

// File: rtl/irqv_sync.sv
module irqv_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/irqv_ext_req.sv
module irqv_ext_req #(
  parameter bit LEVEL_SENS = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_ns_i,   // synchronised pin, active low
  input  logic clr_i,
  output logic pend_o
);

  logic prev_q;
  logic lat_q;
  logic fall;

  assign fall = prev_q & ~pin_ns_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= pin_ns_i;
      if (fall)       lat_q <= 1'b1;   // new edge beats a same-cycle clear
      else if (clr_i) lat_q <= 1'b0;
    end
  end

  generate
    if (LEVEL_SENS) begin : g_level
      assign pend_o = lat_q | ~pin_ns_i;
    end else begin : g_edge
      assign pend_o = lat_q;
    end
  endgenerate

endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              irq_pend_i,
  input  logic              tmr_pend_i,
  input  logic              imask_i,
  input  logic              swi_i,
  input  logic              wait_i,
  output irq_src_e          src_o,
  output logic [ADDR_W-1:0] vec_o
);

  localparam logic [ADDR_W-1:0] VEC_TOP  = '1;
  localparam logic [ADDR_W-1:0] VEC_RST  = VEC_TOP - ADDR_W'(VOFF_RST);
  localparam logic [ADDR_W-1:0] VEC_SWI  = VEC_TOP - ADDR_W'(VOFF_SWI);
  localparam logic [ADDR_W-1:0] VEC_IRQ  = VEC_TOP - ADDR_W'(VOFF_IRQ);
  localparam logic [ADDR_W-1:0] VEC_TMR  = VEC_TOP - ADDR_W'(VOFF_TMR);
  localparam logic [ADDR_W-1:0] VEC_TMRW = VEC_TOP - ADDR_W'(VOFF_TMR_WAIT);

  logic hw_ok;
  assign hw_ok = ~imask_i;

  always_comb begin
    src_o = SRC_NONE;
    vec_o = VEC_RST;
    if (hw_ok && irq_pend_i) begin
      src_o = SRC_IRQ;
      vec_o = VEC_IRQ;
    end else if (hw_ok && tmr_pend_i) begin
      src_o = SRC_TMR;
      vec_o = wait_i ? VEC_TMRW : VEC_TMR;
    end else if (swi_i) begin
      src_o = SRC_SWI;
      vec_o = VEC_SWI;
    end
  end

endmodule

// File: rtl/irqv_unit.sv
module irqv_unit
  import irqv_pkg::*;
#(
  parameter int unsigned ADDR_W      = 13,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          LEVEL_SENS  = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_ni,
  input  logic              tmr_req_i,
  input  logic              imask_i,
  input  logic              eoi_i,
  input  logic              swi_i,
  input  logic              wait_i,
  input  logic              ack_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] vec_o
);

  localparam logic [ADDR_W-1:0] VEC_TOP = '1;
  localparam logic [ADDR_W-1:0] VEC_RST = VEC_TOP - ADDR_W'(VOFF_RST);

  logic              irq_s;
  logic              irq_pend;
  logic              irq_clr;
  logic              busy_q;
  logic              wait_q;
  irq_src_e          src_q;
  logic [ADDR_W-1:0] vec_q;
  irq_src_e          arb_src;
  logic [ADDR_W-1:0] arb_vec;
  logic              accept;
  logic              done;

  irqv_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (irq_ni),
    .q_o    (irq_s)
  );

  irqv_ext_req #(
    .LEVEL_SENS (LEVEL_SENS)
  ) u_ext (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pin_ns_i (irq_s),
    .clr_i    (irq_clr),
    .pend_o   (irq_pend)
  );

  irqv_arbiter #(
    .ADDR_W (ADDR_W)
  ) u_arb (
    .irq_pend_i (irq_pend),
    .tmr_pend_i (tmr_req_i),
    .imask_i    (imask_i),
    .swi_i      (swi_i),
    .wait_i     (wait_q),
    .src_o      (arb_src),
    .vec_o      (arb_vec)
  );

  assign done    = ack_i & busy_q;
  assign irq_clr = done & (src_q == SRC_IRQ);
  assign accept  = eoi_i & ~busy_q & (arb_src != SRC_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      src_q  <= SRC_NONE;
      vec_q  <= VEC_RST;
    end else if (accept) begin
      busy_q <= 1'b1;
      src_q  <= arb_src;
      vec_q  <= arb_vec;
    end else if (done) begin
      busy_q <= 1'b0;
      src_q  <= SRC_NONE;
    end
  end

  // wait flag: clear on first acknowledge wins over a held wait_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wait_q <= 1'b0;
    else if (done)   wait_q <= 1'b0;
    else if (wait_i) wait_q <= 1'b1;
  end

  assign take_o = busy_q;
  assign vec_o  = vec_q;

endmodule

// File: rtl/irqv_unit_chk.sv
module irqv_unit_chk
  import irqv_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              eoi_i,
  input logic              imask_i,
  input logic              ack_i,
  input logic              take_o,
  input logic [ADDR_W-1:0] vec_o,
  input logic              irq_pend,
  input logic              wait_q
);

  localparam logic [ADDR_W-1:0] VEC_TOP  = '1;
  localparam logic [ADDR_W-1:0] VEC_SWI  = VEC_TOP - ADDR_W'(VOFF_SWI);
  localparam logic [ADDR_W-1:0] VEC_IRQ  = VEC_TOP - ADDR_W'(VOFF_IRQ);
  localparam logic [ADDR_W-1:0] VEC_TMR  = VEC_TOP - ADDR_W'(VOFF_TMR);
  localparam logic [ADDR_W-1:0] VEC_TMRW = VEC_TOP - ADDR_W'(VOFF_TMR_WAIT);

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_idle_R1: assert (!take_o);
  end

  assert_take_on_boundary_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(take_o) |-> $past(eoi_i));

  assert_irq_before_tmr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(take_o) && (vec_o == VEC_TMR || vec_o == VEC_TMRW)) |-> !$past(irq_pend));

  assert_mask_blocks_hw_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(take_o) && $past(imask_i)) |-> vec_o == VEC_SWI);

  assert_irq_needs_pend_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(take_o) && vec_o == VEC_IRQ) |-> $past(irq_pend));

  assert_wait_vec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(take_o) && vec_o == VEC_TMRW) |-> $past(wait_q));

  assert_wait_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && ack_i) |=> !wait_q);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !ack_i) |=> (take_o && $stable(vec_o)));

endmodule

bind irqv_unit irqv_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .eoi_i    (eoi_i),
  .imask_i  (imask_i),
  .ack_i    (ack_i),
  .take_o   (take_o),
  .vec_o    (vec_o),
  .irq_pend (irq_pend),
  .wait_q   (wait_q)
);

// File: tb/irqv_unit_test.sv
module irqv_unit_test;

  localparam logic [12:0] VR = 13'h1FFE;
  localparam logic [12:0] VS = 13'h1FFC;
  localparam logic [12:0] VI = 13'h1FFA;
  localparam logic [12:0] VT = 13'h1FF8;
  localparam logic [12:0] VW = 13'h1FF6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic irq_ni = 1'b1, tmr_req_i = 1'b0, imask_i = 1'b0, eoi_i = 1'b0;
  logic swi_i = 1'b0, wait_i = 1'b0, ack_i = 1'b0;
  logic take_e, take_l;
  logic [12:0] vec_e, vec_l;

  always #5 clk = ~clk;

  irqv_unit #(.LEVEL_SENS(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_ni(irq_ni), .tmr_req_i(tmr_req_i),
    .imask_i(imask_i), .eoi_i(eoi_i), .swi_i(swi_i), .wait_i(wait_i),
    .ack_i(ack_i), .take_o(take_e), .vec_o(vec_e));

  irqv_unit #(.LEVEL_SENS(1'b1)) uut_lvl (
    .clk_i(clk), .rst_ni(rst_ni), .irq_ni(irq_ni), .tmr_req_i(tmr_req_i),
    .imask_i(imask_i), .eoi_i(eoi_i), .swi_i(swi_i), .wait_i(wait_i),
    .ack_i(ack_i), .take_o(take_l), .vec_o(vec_l));

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // reference model, index 0 edge variant, 1 level variant
  bit          lat   [2];
  bit          busy  [2];
  bit          isirq [2];
  bit          waitf [2];
  logic [12:0] vexp  [2];
  bit pin = 1, tmr = 0, msk = 0, swi = 0, wt = 0;

  function automatic logic [13:0] predict(input int k);
    bit pend;
    pend = (k == 0) ? lat[0] : (lat[1] | !pin);
    if (!msk && pend)      return {1'b1, VI};
    else if (!msk && tmr)  return {1'b1, waitf[k] ? VW : VT};
    else if (swi)          return {1'b1, VS};
    else                   return {1'b0, vexp[k]};
  endfunction

  task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input bit v);
    if (pin && !v) begin lat[0] = 1; lat[1] = 1; end
    pin = v; irq_ni = v;
    step(4);
  endtask

  task automatic set_wait(input bit v);
    wt = v; wait_i = v;
    if (v) begin waitf[0] = 1; waitf[1] = 1; end
    step(1);
  endtask

  task automatic set_ctl(input bit t, input bit m, input bit s);
    tmr = t; msk = m; swi = s;
    tmr_req_i = t; imask_i = m; swi_i = s;
    step(1);
  endtask

  task automatic boundary(input string tag);
    logic [13:0] p;
    for (int k = 0; k < 2; k++) begin
      if (!busy[k]) begin
        p = predict(k);
        if (p[13]) begin
          busy[k] = 1; vexp[k] = p[12:0]; isirq[k] = (p[12:0] == VI);
        end
      end
    end
    eoi_i = 1'b1;
    step(1);
    eoi_i = 1'b0;
    check({tag, " edge"},  {take_e, vec_e}, {busy[0], vexp[0]});
    check({tag, " level"}, {take_l, vec_l}, {busy[1], vexp[1]});
  endtask

  task automatic acknowledge(input string tag);
    ack_i = 1'b1;
    step(1);
    ack_i = 1'b0;
    for (int k = 0; k < 2; k++) begin
      if (busy[k]) begin
        busy[k] = 0;
        if (isirq[k]) lat[k] = 0;
        waitf[k] = wt;
      end
    end
    step(2);
    check({tag, " ack edge"},  {31'd0, take_e}, 32'd0);
    check({tag, " ack level"}, {31'd0, take_l}, 32'd0);
  endtask

  initial begin
    #1ms;
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) begin
      lat[k] = 0; busy[k] = 0; isirq[k] = 0; waitf[k] = 0; vexp[k] = VR;
    end
    void'($urandom(32'h5EED_1234));
    step(3);
    check("R1 reset edge",  {take_e, vec_e}, {1'b0, VR});
    check("R1 reset level", {take_l, vec_l}, {1'b0, VR});
    rst_ni = 1'b1;
    step(2);
    check("R1 after release", {take_e, vec_e, take_l, vec_l}, {1'b0, VR, 1'b0, VR});

    // R2: pending but no strobe
    set_pin(0);
    step(6);
    check("R2 no strobe", {take_e, take_l}, 2'b00);
    boundary("R3 irq alone");
    acknowledge("R8 irq");
    // R6 / R7: pin still low after service
    boundary("R6 R7 pin held low");
    acknowledge("R7 level");
    set_pin(1);

    // R4: pulse while masked is kept
    set_ctl(0, 1, 0);
    set_pin(0); set_pin(1);
    boundary("R4 masked no take");
    set_ctl(0, 0, 0);
    boundary("R4 latched pulse after unmask");
    acknowledge("R4");

    // R3 / R8: both pending
    set_ctl(1, 1, 0);
    set_pin(0); set_pin(1);
    set_ctl(1, 0, 0);
    boundary("R3 irq over timer");
    acknowledge("R3");
    boundary("R3 R8 timer next");
    acknowledge("R8 timer ack keeps nothing");
    set_ctl(0, 0, 0);
    boundary("R8 nothing left");

    // R5: software interrupt
    set_ctl(1, 1, 1);
    boundary("R5 swi masked");
    acknowledge("R5");
    set_ctl(1, 0, 1);
    boundary("R5 hw over swi");
    acknowledge("R5");
    set_ctl(0, 0, 1);
    boundary("R5 swi alone");
    acknowledge("R5");
    set_ctl(0, 0, 0);

    // R9: wake from wait with both pending
    set_wait(1);
    set_ctl(1, 0, 0);
    set_pin(0); set_pin(1);
    boundary("R9 irq first in wait");
    set_wait(0);
    acknowledge("R9");
    boundary("R9 timer normal vector");
    acknowledge("R9");
    set_wait(1);
    boundary("R9 timer wait vector");
    set_wait(0);
    acknowledge("R9");

    // R10: strobes during an outstanding take
    boundary("R10 timer take");
    set_ctl(1, 1, 1);
    boundary("R10 strobe ignored");
    acknowledge("R10");
    set_ctl(0, 0, 0);

    // random phase
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 7);
      case (op)
        0: set_pin(!pin);
        1: set_ctl(!tmr, msk, swi);
        2: set_ctl(tmr, !msk, swi);
        3: set_ctl(tmr, msk, !swi);
        4: set_wait(!wt);
        default: begin
          boundary("R3 R5 R9 random");
          if ($urandom % 4 == 0) boundary("R10 random");
          if (busy[0] || busy[1]) acknowledge("R8 random");
        end
      endcase
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule